// File: doc/BRIEF.md
# DMA Channel Start Trigger

This block keeps the software-visible setup registers of a multi-channel DMA unit. Each channel has a base address, a block control word and a channel control word, and one shared register holds a per-channel enable bit. When software writes a channel control word with the start bit set and that channel is enabled, the block sends a single-cycle start request to the channel's transfer engine. With the request the engine sees the base address, the block control and the channel control values. The engine reports that it has finished through a per-channel done input, and this clears the start bit.

A single register port handles both writes and reads. Writes may be 32 bits wide, or 16 bits wide with zero-extension to 32 bits. Reads return the register selected by the current address, combinationally. Channel slot 5 is not built: its offsets behave like unmapped space. A start write to a channel whose start bit is already set still issues a request when the channel is enabled, and it also raises a one-cycle diagnostic flag.

Top module: `dma_start_ctl`

## Requirements
- R1: After a synchronous reset every register reads 0, and no start or diagnostic output is high.
- R2: For each present channel n, the base address register at offset 0x1080+0x10*n and the block control register at offset 0x1084+0x10*n store the written value. They read it back and drive it on that channel's base and block outputs. Writing them never causes a start.
- R3: Channel n's control register answers at both 0x1088+0x10*n and 0x108C+0x10*n. A write through either offset is visible through the other offset.
- R4: A control write to channel n raises that channel's start output for exactly the one cycle after the write edge, and only when two conditions hold: bit 24 of the written value is 1, and bit 4*n+3 of the enable register is 1.
- R5: The enable register at 0x10F0 stores all 32 bits and reads them back. Writing it starts nothing.
- R6: A 16-bit write (wide input low) stores the low 16 bits of the data zero-extended to 32 bits. A 16-bit control write therefore never sets bit 24 and never starts a channel.
- R7: Channel slot 5 is absent. Writes to 0x10D0 through 0x10DC change nothing and read back 0. Its start, diagnostic and value outputs stay 0, even when enable bit 23 is set.
- R8: A high done input for channel n clears bit 24 of its control register at the next edge. A control write in the same cycle takes precedence.
- R9: A control write with bit 24 set, made while bit 24 of that control register is already 1, pulses the channel's diagnostic output for one cycle. When the channel is enabled it also issues a start again.
- R10: Addresses outside the mapped registers, and addresses with bits 1:0 not zero, read 0. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wide | input | 1 | 1: 32-bit write, 0: 16-bit write (zero-extended) |
| bus_addr | input | AW (16) | Register byte offset |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data for bus_addr, combinational |
| eng_done | input | NCH (7) | Per-channel transfer finished, clears the start bit |
| eng_start | output | NCH (7) | Per-channel one-cycle start request |
| eng_restart | output | NCH (7) | Per-channel one-cycle diagnostic: start written while busy |
| eng_base | output | NCH*DW | Base address values, channel n in bits n*DW +: DW |
| eng_blk | output | NCH*DW | Block control values, same packing |
| eng_ctrl | output | NCH*DW | Channel control values, same packing |

## Verification
The assertions expect the done inputs and the write strobe to be free of X once reset has been released. They also expect a done input to come only from an engine that this block started, although a done that arrives while idle is harmless because it only clears a bit that is already clear. The stimulus drives every input on the falling clock edge and holds it through the next rising edge. It raises done only for channels whose start bit it has set, and it never goes outside the 16-bit offset space. Reset is held for several cycles before any access, so every register-held property starts from known zero state.

// File: rtl/dmast_pkg.sv
package dmast_pkg;

    localparam int unsigned START_BIT = 24;
    localparam logic [15:0] SLOT_ORIGIN = 16'h1080;
    localparam logic [15:0] SLOT_STRIDE = 16'h0010;
    localparam logic [15:0] ENABLE_OFS  = 16'h10F0;
    localparam int unsigned CHW = 3;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_BASE,
        SEL_BLK,
        SEL_CTRL,
        SEL_ENABLE
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e       sel;
        logic [CHW-1:0] chan;
    } reg_hit_t;

    function automatic int unsigned enable_pos(input int unsigned ch);
        return 4 * ch + 3;
    endfunction

    function automatic logic [31:0] widen(input logic [31:0] d, input logic wide);
        return wide ? d : {16'h0000, d[15:0]};
    endfunction

endpackage

// File: rtl/dmast_decode.sv
module dmast_decode
    import dmast_pkg::*;
#(
    parameter int unsigned AW = 16,
    parameter int unsigned NCH = 7,
    parameter logic [NCH-1:0] PRESENT = 7'b1011111
) (
    input  logic [AW-1:0] addr,
    output reg_hit_t      hit
);

    localparam int unsigned SLOT_SHIFT = 4;

    always_comb begin
        hit.sel  = SEL_NONE;
        hit.chan = '0;
        if (addr[1:0] == 2'b00) begin
            if (addr == AW'(ENABLE_OFS)) begin
                hit.sel = SEL_ENABLE;
            end else begin
                for (int unsigned n = 0; n < NCH; n++) begin
                    if (PRESENT[n] &&
                        addr[AW-1:SLOT_SHIFT] ==
                        AW'(32'(SLOT_ORIGIN) + n * 32'(SLOT_STRIDE)) >> SLOT_SHIFT) begin
                        hit.chan = CHW'(n);
                        case (addr[3:2])
                            2'd0:    hit.sel = SEL_BASE;
                            2'd1:    hit.sel = SEL_BLK;
                            default: hit.sel = SEL_CTRL;
                        endcase
                    end
                end
            end
        end
    end

endmodule

// File: rtl/dmast_chan.sv
module dmast_chan
    import dmast_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_base,
    input  logic          wr_blk,
    input  logic          wr_ctrl,
    input  logic [DW-1:0] wdata,
    input  logic          enabled,
    input  logic          done,
    output logic [DW-1:0] base_q,
    output logic [DW-1:0] blk_q,
    output logic [DW-1:0] ctrl_q,
    output logic          start,
    output logic          restart
);

    logic go_bit;
    assign go_bit = wdata[START_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q  <= '0;
            blk_q   <= '0;
            ctrl_q  <= '0;
            start   <= 1'b0;
            restart <= 1'b0;
        end else begin
            start   <= wr_ctrl && go_bit && enabled;
            restart <= wr_ctrl && go_bit && ctrl_q[START_BIT];
            if (wr_base) base_q <= wdata;
            if (wr_blk)  blk_q  <= wdata;
            if (wr_ctrl) begin
                ctrl_q <= wdata;
            end else if (done) begin
                ctrl_q[START_BIT] <= 1'b0;
            end
        end
    end

    // A start request always coincides with a busy control word
    p_start_busy_r4: assert property (@(posedge clk) disable iff (rst)
        start |-> ctrl_q[START_BIT]);

    p_done_clears_r8: assert property (@(posedge clk) disable iff (rst)
        (done && !wr_ctrl) |=> !ctrl_q[START_BIT]);

    p_base_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!wr_base && !wr_blk) |=> ($stable(base_q) && $stable(blk_q)));

    p_restart_prev_busy_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && go_bit && ctrl_q[START_BIT]) |=> restart);

    p_start_one_cycle_r4: assert property (@(posedge clk) disable iff (rst)
        (start && !wr_ctrl) |=> !start);

endmodule

// File: rtl/dma_start_ctl.sv
module dma_start_ctl
    import dmast_pkg::*;
#(
    parameter int unsigned AW = 16,
    parameter int unsigned DW = 32,
    parameter int unsigned NCH = 7,
    parameter logic [NCH-1:0] PRESENT = 7'b1011111
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic              bus_wide,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic [NCH-1:0]    eng_done,
    output logic [NCH-1:0]    eng_start,
    output logic [NCH-1:0]    eng_restart,
    output logic [NCH*DW-1:0] eng_base,
    output logic [NCH*DW-1:0] eng_blk,
    output logic [NCH*DW-1:0] eng_ctrl
);

    reg_hit_t      hit;
    logic [DW-1:0] wdata_x;
    logic [DW-1:0] en_q;

    dmast_decode #(.AW(AW), .NCH(NCH), .PRESENT(PRESENT)) i_decode (
        .addr (bus_addr),
        .hit  (hit)
    );

    assign wdata_x = widen(bus_wdata, bus_wide);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (bus_we && hit.sel == SEL_ENABLE) begin
            en_q <= wdata_x;
        end
    end

    for (genvar n = 0; n < NCH; n++) begin : g_chan
        if (PRESENT[n]) begin : g_on
            logic sel_me;
            assign sel_me = bus_we && (hit.chan == CHW'(n));
            dmast_chan #(.DW(DW)) i_chan (
                .clk     (clk),
                .rst     (rst),
                .wr_base (sel_me && hit.sel == SEL_BASE),
                .wr_blk  (sel_me && hit.sel == SEL_BLK),
                .wr_ctrl (sel_me && hit.sel == SEL_CTRL),
                .wdata   (wdata_x),
                .enabled (en_q[enable_pos(n)]),
                .done    (eng_done[n]),
                .base_q  (eng_base[n*DW +: DW]),
                .blk_q   (eng_blk[n*DW +: DW]),
                .ctrl_q  (eng_ctrl[n*DW +: DW]),
                .start   (eng_start[n]),
                .restart (eng_restart[n])
            );
        end else begin : g_off
            assign eng_base[n*DW +: DW] = '0;
            assign eng_blk[n*DW +: DW]  = '0;
            assign eng_ctrl[n*DW +: DW] = '0;
            assign eng_start[n]         = 1'b0;
            assign eng_restart[n]       = 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (hit.sel)
            SEL_ENABLE: bus_rdata = en_q;
            SEL_BASE:   bus_rdata = eng_base[hit.chan*DW +: DW];
            SEL_BLK:    bus_rdata = eng_blk[hit.chan*DW +: DW];
            SEL_CTRL:   bus_rdata = eng_ctrl[hit.chan*DW +: DW];
            default:    bus_rdata = '0;
        endcase
    end

    p_enable_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !(bus_we && hit.sel == SEL_ENABLE) |=> $stable(en_q));

    p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (hit.sel == SEL_NONE) |-> (bus_rdata == '0));

    p_start_needs_enable_r4: assert property (@(posedge clk) disable iff (rst)
        (|(eng_start & ~PRESENT)) == 1'b0);

endmodule

// File: tb/test_dma_start_ctl.sv
module test_dma_start_ctl;

    localparam int NCH = 7;
    localparam int DW  = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_we = 1'b0;
    logic              bus_wide = 1'b1;
    logic [15:0]       bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NCH-1:0]    eng_done = '0;
    logic [NCH-1:0]    eng_start;
    logic [NCH-1:0]    eng_restart;
    logic [NCH*DW-1:0] eng_base;
    logic [NCH*DW-1:0] eng_blk;
    logic [NCH*DW-1:0] eng_ctrl;

    dma_start_ctl i_dma_start_ctl (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_wide(bus_wide),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_done(eng_done), .eng_start(eng_start), .eng_restart(eng_restart),
        .eng_base(eng_base), .eng_blk(eng_blk), .eng_ctrl(eng_ctrl)
    );

    always #5 clk = ~clk;

    int total = 0;
    int bad = 0;

    // behavioural reference state
    logic [31:0]    m_base [NCH];
    logic [31:0]    m_blk  [NCH];
    logic [31:0]    m_ctrl [NCH];
    logic [31:0]    m_en;
    logic [NCH-1:0] m_start;
    logic [NCH-1:0] m_restart;

    // kind: 0 none, 1 base, 2 blk, 3 ctrl, 4 enable
    function automatic int kind_of(input logic [15:0] a, output int ch);
        int off;
        ch = 0;
        if (a == 16'h10F0) return 4;
        if (a[1:0] != 2'b00 || a < 16'h1080) return 0;
        off = int'(a) - 'h1080;
        ch = off / 16;
        if (ch >= NCH || ch == 5) return 0;
        case ((off % 16) / 4)
            0: return 1;
            1: return 2;
            default: return 3;
        endcase
    endfunction

    function automatic logic [31:0] model_read(input logic [15:0] a);
        int ch;
        int k;
        k = kind_of(a, ch);
        case (k)
            1: return m_base[ch];
            2: return m_blk[ch];
            3: return m_ctrl[ch];
            4: return m_en;
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int n = 0; n < NCH; n++) begin
                m_base[n] = 0; m_blk[n] = 0; m_ctrl[n] = 0;
            end
            m_en = 0; m_start = 0; m_restart = 0;
        end else begin
            int ch;
            int k;
            logic [31:0] d;
            logic [31:0] old_en;
            logic        was_busy;
            old_en = m_en;
            m_start = 0;
            m_restart = 0;
            k = kind_of(bus_addr, ch);
            d = bus_wide ? bus_wdata : (bus_wdata & 32'h0000FFFF);
            for (int n = 0; n < NCH; n++) begin
                was_busy = m_ctrl[n][24];
                if (bus_we && k == 3 && ch == n) begin
                    m_ctrl[n] = d;
                    m_restart[n] = d[24] && was_busy;
                    m_start[n] = d[24] && old_en[4*n+3];
                end else if (eng_done[n] && n != 5) begin
                    m_ctrl[n][24] = 1'b0;
                end
            end
            if (bus_we) begin
                if (k == 1) m_base[ch] = d;
                if (k == 2) m_blk[ch] = d;
                if (k == 4) m_en = d;
            end
        end
    end

    task automatic check32(input string tag, input string what,
                           input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        check32(tag, "rdata", bus_rdata, model_read(bus_addr));
        check32(tag, "start", 32'(eng_start), 32'(m_start));
        check32(tag, "restart", 32'(eng_restart), 32'(m_restart));
        for (int n = 0; n < NCH; n++) begin
            check32(tag, "base_out", eng_base[n*DW +: DW], m_base[n]);
            check32(tag, "blk_out",  eng_blk[n*DW +: DW],  m_blk[n]);
            check32(tag, "ctrl_out", eng_ctrl[n*DW +: DW], m_ctrl[n]);
        end
    endtask

    task automatic tick(input string tag);
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d,
                      input logic wide, input string tag);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_wide = wide;
        tick(tag);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, input string tag);
        bus_we = 1'b0; bus_addr = a;
        tick(tag);
    endtask

    initial begin
        #2_000_000;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        compare("R1");
        rst = 1'b0;
        rd(16'h1080, "R1"); rd(16'h10E8, "R1"); rd(16'h10F0, "R1");

        wr(16'h1080, 32'hA000_0010, 1'b1, "R2");
        wr(16'h10A4, 32'h0004_0020, 1'b1, "R2");
        wr(16'h10E0, 32'h001F_FFFC, 1'b1, "R2");
        rd(16'h1080, "R2"); rd(16'h10A4, "R2"); rd(16'h10E0, "R2");

        wr(16'h1098, 32'h0100_0201, 1'b1, "R4 disabled");
        rd(16'h109C, "R3");
        wr(16'h109C, 32'h0000_0200, 1'b1, "R3");
        rd(16'h1098, "R3");

        wr(16'h10F0, 32'h0888_8888, 1'b1, "R5");
        rd(16'h10F0, "R5");

        wr(16'h10EC, 32'h1100_0002, 1'b1, "R4 start");
        rd(16'h10E8, "R4 pulse ends");
        wr(16'h10E8, 32'h1100_0002, 1'b1, "R9");
        rd(16'h10E8, "R9");

        eng_done[6] = 1'b1;
        rd(16'h10EC, "R8");
        eng_done[6] = 1'b0;
        rd(16'h10EC, "R8");

        wr(16'h1088, 32'h0100_0000, 1'b1, "R4 ch0");
        eng_done[0] = 1'b1;
        wr(16'h108C, 32'h0100_0401, 1'b1, "R8 write wins");
        eng_done[0] = 1'b0;
        rd(16'h1088, "R8");

        wr(16'h10B0, 32'hFFFF_1234, 1'b0, "R6");
        wr(16'h10B8, 32'h0100_FFFF, 1'b0, "R6 no start");
        rd(16'h10B0, "R6");

        wr(16'h10F0, 32'h0888_8888 | 32'h0080_0000, 1'b1, "R7");
        wr(16'h10D8, 32'h0100_0000, 1'b1, "R7");
        wr(16'h10D0, 32'h1234_5678, 1'b1, "R7");
        rd(16'h10D8, "R7"); rd(16'h10D4, "R7");

        wr(16'h1100, 32'hDEAD_BEEF, 1'b1, "R10");
        wr(16'h1082, 32'hDEAD_BEEF, 1'b1, "R10");
        rd(16'h1100, "R10"); rd(16'h1080, "R10");

        wr(16'h10F0, 32'h0888_8088, 1'b1, "R5 disable ch2");
        wr(16'h10A8, 32'h0100_0000, 1'b1, "R4 ch2 disabled");
        wr(16'h10C8, 32'h0100_0000, 1'b1, "R4 ch4");
        rd(16'h10C8, "R4");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule